// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block brings a processor core out of reset. When a power-on reset or a manual reset request is released, it reads two words over a simple memory read port. The first word is the starting program counter and the second is the initial stack pointer. The pair of addresses it reads depends on which kind of reset occurred. Once both words have arrived, the block raises a one-cycle start pulse. The fetched PC and SP are presented together with that pulse, and the core begins executing at that PC.

Alongside the fetch, the block owns the reset values of several control registers: the vector base, the four-bit interrupt mask of the status register, the bank-overflow flag and the interrupt controller's bank-number field. It also holds the floating-point control register. A power-on reset loads that register with its start-up constant, while a manual reset leaves it untouched. Outside of a power-on reset, the core can rewrite the floating-point control register through a write port.

Top module: `boot_vector_seq`

## Requirements
- R1: For a power-on reset, the PC word is read from address 0x00000000 and the SP word from address 0x00000004.
- R2: For a manual reset, the PC word is read from address 0x00000008 and the SP word from address 0x0000000C.
- R3: The PC read completes before the SP read is issued. Each read keeps rd_req high with rd_addr stable until a cycle in which rd_ready is high, and the word on rd_data is taken in that cycle.
- R4: boot_start is high for exactly one cycle, in the cycle after the SP read is accepted. At that point boot_pc and boot_sp carry the two fetched words, and they hold those values afterwards.
- R5: When boot_start is high, vbr is 0x00000000, sr_imask is 4'hF, bank_ovf is 0 and bank_num is 0.
- R6: A power-on reset, whether from rst_n or from por_req, sets fpscr to 0x00040001.
- R7: A manual reset leaves fpscr unchanged. Outside of a power-on request, fpscr_we loads fpscr_wdata on the next edge.
- R8: From the cycle after a reset request is first sampled high, and for as long as it stays high, rd_req and boot_start are low. After the request is released, the sequence restarts from the PC read, even if it was in progress.
- R9: If por_req and man_req are both high, the request is treated as a power-on reset.
- R10: After rst_n is released, the block runs a power-on sequence on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| por_req | input | 1 | Power-on reset request, held while active |
| man_req | input | 1 | Manual reset request, held while active |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | AW | Read address |
| rd_ready | input | 1 | Memory accepts the read; rd_data is valid |
| rd_data | input | DW | Read data |
| boot_start | output | 1 | One-cycle pulse: core starts at boot_pc |
| boot_pc | output | DW | Fetched initial program counter |
| boot_sp | output | DW | Fetched initial stack pointer |
| vbr | output | DW | Vector base register value |
| sr_imask | output | 4 | Status register interrupt mask |
| bank_ovf | output | 1 | Register bank overflow flag |
| bank_num | output | BNW | Interrupt controller bank number |
| fpscr_we | input | 1 | Core write enable for fpscr |
| fpscr_wdata | input | DW | Core write data for fpscr |
| fpscr | output | DW | Floating-point status/control register |

## Verification
The assertions check the following on every cycle:
- the vector address against the reset kind;
- that a read request and its address are held while memory is not ready;
- that the SP read only follows an accepted PC read;
- the single-cycle start pulse;
- the control values at start;
- the fpscr behaviour under each kind of request;
- silence of the read port while a request is held.

Only the bench scenarios can show the following:
- that the captured words actually come from the right addresses under varied memory latencies;
- that a request arriving mid-sequence restarts from the PC read;
- that a rewritten fpscr survives a manual reset but not a power-on reset.

// File: rtl/boot_vec_pkg.sv
package boot_vec_pkg;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_PC   = 3'd1,
    ST_SP   = 3'd2,
    ST_GO   = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_e;

  typedef enum logic {
    RK_POWER  = 1'b0,
    RK_MANUAL = 1'b1
  } rst_kind_e;

  // byte offset of a vector slot: manual reset uses the second pair of words
  function automatic logic [31:0] vec_offset(rst_kind_e kind, logic sp_slot);
    return {28'd0, kind == RK_MANUAL, sp_slot, 2'b00};
  endfunction

  // power-on wins over manual when both are requested
  function automatic rst_kind_e pick_kind(logic por, logic man);
    if (por) return RK_POWER;
    if (man) return RK_MANUAL;
    return RK_POWER;
  endfunction

endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_vec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_req,
  input  logic              man_req,
  input  logic              rd_ready,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic              pc_load,
  output logic              sp_load,
  output logic              boot_start,
  output logic              pc_phase,
  output logic              sp_phase,
  output rst_kind_e         kind
);

  seq_state_e state_q;
  logic       any_req;
  logic       ack;

  assign any_req    = por_req | man_req;
  assign pc_phase   = (state_q == ST_PC);
  assign sp_phase   = (state_q == ST_SP);
  assign rd_req     = pc_phase | sp_phase;
  assign ack        = rd_req & rd_ready;
  assign pc_load    = pc_phase & rd_ready;
  assign sp_load    = sp_phase & rd_ready;
  assign boot_start = (state_q == ST_GO);
  assign rd_addr    = AW'(vec_offset(kind, sp_phase));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PC;
      kind    <= RK_POWER;
    end else if (any_req) begin
      state_q <= ST_HOLD;
      kind    <= pick_kind(por_req, man_req);
    end else begin
      unique case (state_q)
        ST_HOLD: state_q <= ST_PC;
        ST_PC:   if (ack) state_q <= ST_SP;
        ST_SP:   if (ack) state_q <= ST_GO;
        ST_GO:   state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/boot_seq_capture.sv
module boot_seq_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_load,
  input  logic          sp_load,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] boot_pc,
  output logic [DW-1:0] boot_sp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pc <= '0;
      boot_sp <= '0;
    end else begin
      if (pc_load) boot_pc <= rd_data;
      if (sp_load) boot_sp <= rd_data;
    end
  end

endmodule

// File: rtl/boot_ctl_init.sv
module boot_ctl_init #(
  parameter int          DW      = 32,
  parameter int          BNW     = 4,
  parameter logic [31:0] FP_INIT = 32'h0004_0001
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por_req,
  input  logic           man_req,
  input  logic           fpscr_we,
  input  logic [DW-1:0]  fpscr_wdata,
  output logic [DW-1:0]  vbr,
  output logic [3:0]     sr_imask,
  output logic           bank_ovf,
  output logic [BNW-1:0] bank_num,
  output logic [DW-1:0]  fpscr
);

  localparam logic [DW-1:0] FP_RST = DW'(FP_INIT);

  // values shared by both kinds of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbr      <= '0;
      sr_imask <= 4'hF;
      bank_ovf <= 1'b0;
      bank_num <= '0;
    end else if (por_req | man_req) begin
      vbr      <= '0;
      sr_imask <= 4'hF;
      bank_ovf <= 1'b0;
      bank_num <= '0;
    end
  end

  // floating-point control: only power-on reset reloads it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fpscr <= FP_RST;
    else if (por_req)  fpscr <= FP_RST;
    else if (fpscr_we) fpscr <= fpscr_wdata;
  end

endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
  import boot_vec_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter int          BNW     = 4,
  parameter logic [31:0] FP_INIT = 32'h0004_0001
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por_req,
  input  logic           man_req,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_ready,
  input  logic [DW-1:0]  rd_data,
  output logic           boot_start,
  output logic [DW-1:0]  boot_pc,
  output logic [DW-1:0]  boot_sp,
  output logic [DW-1:0]  vbr,
  output logic [3:0]     sr_imask,
  output logic           bank_ovf,
  output logic [BNW-1:0] bank_num,
  input  logic           fpscr_we,
  input  logic [DW-1:0]  fpscr_wdata,
  output logic [DW-1:0]  fpscr
);

  // named internal events, used by the bound checker
  logic      pc_load;
  logic      sp_load;
  logic      pc_phase;
  logic      sp_phase;
  rst_kind_e kind;

  boot_seq_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_req    (por_req),
    .man_req    (man_req),
    .rd_ready   (rd_ready),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .pc_load    (pc_load),
    .sp_load    (sp_load),
    .boot_start (boot_start),
    .pc_phase   (pc_phase),
    .sp_phase   (sp_phase),
    .kind       (kind)
  );

  boot_seq_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_load (pc_load),
    .sp_load (sp_load),
    .rd_data (rd_data),
    .boot_pc (boot_pc),
    .boot_sp (boot_sp)
  );

  boot_ctl_init #(.DW(DW), .BNW(BNW), .FP_INIT(FP_INIT)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_req     (por_req),
    .man_req     (man_req),
    .fpscr_we    (fpscr_we),
    .fpscr_wdata (fpscr_wdata),
    .vbr         (vbr),
    .sr_imask    (sr_imask),
    .bank_ovf    (bank_ovf),
    .bank_num    (bank_num),
    .fpscr       (fpscr)
  );

endmodule

// File: rtl/boot_vector_seq_chk.sv
module boot_vector_seq_chk
  import boot_vec_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter int          BNW     = 4,
  parameter logic [31:0] FP_INIT = 32'h0004_0001
) (
  input logic           clk,
  input logic           rst_n,
  input logic           por_req,
  input logic           man_req,
  input logic           rd_req,
  input logic [AW-1:0]  rd_addr,
  input logic           rd_ready,
  input logic           boot_start,
  input logic [DW-1:0]  vbr,
  input logic [3:0]     sr_imask,
  input logic           bank_ovf,
  input logic [BNW-1:0] bank_num,
  input logic           fpscr_we,
  input logic [DW-1:0]  fpscr,
  input logic           pc_phase,
  input logic           sp_phase,
  input rst_kind_e      kind
);

  AST_POR_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && kind == RK_POWER) |-> rd_addr == (sp_phase ? AW'(4) : AW'(0))); // R1
  AST_MAN_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && kind == RK_MANUAL) |-> rd_addr == (sp_phase ? AW'(12) : AW'(8))); // R2
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready && !por_req && !man_req) |=> (rd_req && $stable(rd_addr))); // R3
  AST_PC_BEFORE_SP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sp_phase) |-> $past(pc_phase && rd_ready)); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |=> !boot_start); // R4
  AST_START_AFTER_SP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_start) |-> $past(sp_phase && rd_ready)); // R4
  AST_INIT_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |-> (vbr == '0 && sr_imask == 4'hF && !bank_ovf && bank_num == '0)); // R5
  AST_FPSCR_POR: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> fpscr == DW'(FP_INIT)); // R6
  AST_FPSCR_MAN: assert property (@(posedge clk) disable iff (!rst_n)
    (man_req && !por_req && !fpscr_we) |=> $stable(fpscr)); // R7
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (por_req || man_req) |=> (!rd_req && !boot_start)); // R8
  AST_POWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> kind == RK_POWER); // R9

endmodule

bind boot_vector_seq boot_vector_seq_chk #(
  .AW(AW), .DW(DW), .BNW(BNW), .FP_INIT(FP_INIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_req    (por_req),
  .man_req    (man_req),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_ready   (rd_ready),
  .boot_start (boot_start),
  .vbr        (vbr),
  .sr_imask   (sr_imask),
  .bank_ovf   (bank_ovf),
  .bank_num   (bank_num),
  .fpscr_we   (fpscr_we),
  .fpscr      (fpscr),
  .pc_phase   (pc_phase),
  .sp_phase   (sp_phase),
  .kind       (kind)
);

// File: tb/boot_vector_seq_test.sv
`timescale 1ns/1ps
module boot_vector_seq_test;

  localparam logic [31:0] FP_CONST = 32'h0004_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_req = 1'b0;
  logic        man_req = 1'b0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        boot_start;
  logic [31:0] boot_pc, boot_sp, vbr, fpscr;
  logic [3:0]  sr_imask;
  logic        bank_ovf;
  logic [3:0]  bank_num;
  logic        fpscr_we = 1'b0;
  logic [31:0] fpscr_wdata = '0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [4];
  int          mem_dly = 0;
  int          wcnt = 0;
  logic [31:0] log_a [8];
  int          log_n = 0;

  always #10 clk = ~clk;

  assign rd_data = mem[rd_addr[3:2]];

  boot_vector_seq uut (
    .clk(clk), .rst_n(rst_n), .por_req(por_req), .man_req(man_req),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .boot_start(boot_start), .boot_pc(boot_pc), .boot_sp(boot_sp),
    .vbr(vbr), .sr_imask(sr_imask), .bank_ovf(bank_ovf), .bank_num(bank_num),
    .fpscr_we(fpscr_we), .fpscr_wdata(fpscr_wdata), .fpscr(fpscr)
  );

  // memory model: answers after mem_dly waiting cycles, logs accepted addresses
  always @(negedge clk) begin
    if (rd_req) begin
      if (wcnt >= mem_dly) begin
        rd_ready = 1'b1;
        if (log_n < 8) log_a[log_n] = rd_addr;
        log_n = log_n + 1;
        wcnt = 0;
      end else begin
        rd_ready = 1'b0;
        wcnt = wcnt + 1;
      end
    end else begin
      rd_ready = 1'b0;
      wcnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    while (!boot_start && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(boot_start, req, "boot_start seen", 32'(boot_start), 32'd1);
  endtask

  // verify one finished sequence; kind 0 power, 1 manual, 2 both
  task automatic check_seq(input int kind, input logic [31:0] pcv, input logic [31:0] spv);
    logic [31:0] base;
    base = (kind == 1) ? 32'h8 : 32'h0;
    check(log_n == 2, "R3", "read count", 32'(log_n), 32'd2);
    check(log_a[0] == base, (kind == 1) ? "R2" : "R1", "PC address", log_a[0], base);
    check(log_a[1] == base + 32'h4, (kind == 1) ? "R2" : "R1", "SP address", log_a[1], base + 32'h4);
    check(boot_pc == pcv, "R4", "boot_pc", boot_pc, pcv);
    check(boot_sp == spv, "R4", "boot_sp", boot_sp, spv);
    check(vbr == 32'h0 && sr_imask == 4'hF && !bank_ovf && bank_num == 4'h0, "R5",
          "init values", {vbr[15:0], 7'd0, bank_ovf, sr_imask, bank_num}, 32'h0000_00F0);
    @(negedge clk);
    check(!boot_start, "R4", "pulse ends", 32'(boot_start), 32'd0);
    check(boot_pc == pcv && boot_sp == spv, "R4", "values held", boot_pc, pcv);
  endtask

  task automatic load_mem(input logic [31:0] pcv, input logic [31:0] spv, input bit manual);
    for (int i = 0; i < 4; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    if (manual) begin mem[2] = pcv; mem[3] = spv; end
    else        begin mem[0] = pcv; mem[1] = spv; end
  endtask

  task automatic request(input int kind, input int hold);
    por_req = (kind != 1);
    man_req = (kind != 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i > 0) check(!rd_req && !boot_start, "R8", "quiet while held", 32'(rd_req), 32'd0);
    end
    por_req = 1'b0;
    man_req = 1'b0;
    log_n = 0;
  endtask

  localparam int NV = 5;
  localparam int          V_KIND [NV] = '{0, 1, 2, 1, 0};
  localparam int          V_DLY  [NV] = '{0, 2, 1, 0, 3};
  localparam logic [31:0] V_PC   [NV] = '{32'h0000_1000, 32'h0000_2400, 32'hFFFF_FFFC,
                                          32'h8000_0000, 32'h1234_5678};
  localparam logic [31:0] V_SP   [NV] = '{32'h2000_FFF0, 32'h2001_0000, 32'h0000_0004,
                                          32'h7FFF_FFFF, 32'h9ABC_DEF0};

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    load_mem(32'h0000_0100, 32'h0000_8000, 1'b0);
    mem_dly = 1;
    @(negedge clk);
    check(!boot_start && fpscr == FP_CONST, "R6", "reset state fpscr", fpscr, FP_CONST);
    check(sr_imask == 4'hF && vbr == 0, "R5", "reset state imask", 32'(sr_imask), 32'hF);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: power-on sequence runs by itself after rst_n
    wait_start("R10");
    check_seq(0, 32'h0000_0100, 32'h0000_8000);

    // table of sequences
    for (int v = 0; v < NV; v++) begin
      load_mem(V_PC[v], V_SP[v], V_KIND[v] == 1);
      mem_dly = V_DLY[v];
      request(V_KIND[v], 3);
      wait_start(V_KIND[v] == 2 ? "R9" : "R4");
      check_seq(V_KIND[v], V_PC[v], V_SP[v]);
    end

    // R8: power-on request arriving after the PC read of a manual sequence
    load_mem(32'h0000_0AA0, 32'h0000_0BB0, 1'b1);
    mem[0] = 32'h0000_0CC0;
    mem[1] = 32'h0000_0DD0;
    mem_dly = 2;
    request(1, 2);
    while (log_n < 1) @(negedge clk);
    @(negedge clk);
    request(0, 3);
    wait_start("R8");
    check_seq(0, 32'h0000_0CC0, 32'h0000_0DD0);

    // R7: core write, then manual reset keeps it, power-on reset restores
    fpscr_wdata = 32'h0000_1234;
    fpscr_we = 1'b1;
    @(negedge clk);
    fpscr_we = 1'b0;
    check(fpscr == 32'h0000_1234, "R7", "fpscr write", fpscr, 32'h0000_1234);
    mem_dly = 0;
    load_mem(32'h10, 32'h20, 1'b1);
    request(1, 2);
    wait_start("R7");
    check(fpscr == 32'h0000_1234, "R7", "fpscr kept by manual", fpscr, 32'h0000_1234);
    @(negedge clk);
    request(0, 2);
    check(fpscr == FP_CONST, "R6", "fpscr after power-on request", fpscr, FP_CONST);
    wait_start("R6");
    @(negedge clk);

    finish_run();
  end

endmodule